// File: doc/BRIEF.md
# Segment Translation Front End

This block is the first stage of a 32-bit address translation path. For each access it looks at the effective address, whether the access is a read, a write or an instruction fetch, the access class (integer, floating point, reservation, cache operation, external control) and three machine-state bits: instruction relocation, data relocation and user mode. It then decides how the access proceeds. With relocation off it returns an identity mapping with full permission. Otherwise it picks one of sixteen segment registers by the top address nibble. Direct-store segments are handled here completely. Ordinary segments are handed on to the page-table stage with a protection key, a no-execute flag, a primary hash and a compare tag.

The block also turns fault outcomes into an exception kind, a 32-bit syndrome word and the faulting address. It does this for the faults it finds itself, and on a second channel for the no-match and protection outcomes reported back by the page-table stage. The segment registers are loaded through a simple write port. All results appear one clock after the request.

Top module: `seg_xlate_front`

## Requirements
- R1: After reset, outValid and walkExcValid are low and stay low until a request or walk response arrives.
- R2: A request with reqValid high produces outValid exactly one cycle later. The segment register used is the one indexed by reqAddr[31:28], as written through the write port in an earlier cycle.
- R3: When a fetch (reqKind 2) occurs with msrInstrReloc low, or a data access (reqKind 0 read, 1 write, 3 treated as read) occurs with msrDataReloc low, the result is outAction 0 (done), outRealAddr equal to reqAddr and outProt 3'b111 (bit0 read, bit1 write, bit2 execute). This holds whatever the segment holds.
- R4: Segment register fields are: bit31 direct-store flag, bit30 supervisor key, bit29 user key, bit28 no-execute, bits 23:0 segment identifier. For an ordinary segment the result is outAction 1 (walk). outKey is bit29 when msrUser is high and bit30 otherwise. outNoExec is bit28. outHash is the identifier XOR reqAddr[27:12]. outTag is {identifier, 1'b0, reqAddr[27:22]}.
- R5: A fetch from an ordinary segment with the no-execute bit set gives outAction 2 (fault), exception kind 1 (instruction) and syndrome 0x10000000, and no walk. Data accesses to that segment still walk.
- R6: A direct-store segment whose bits 28:20 equal 0x07F gives outAction 0, outRealAddr {segment bits 3:0, reqAddr[27:0]} and outProt 3'b111, for every kind and class.
- R7: In any other direct-store segment, a fetch faults with exception kind 1 and syndrome 0x10000000.
- R8: In such a segment, data accesses are filtered by reqClass (0 integer, 1 float, 2 reservation, 3 cache op, 4 external, 5 to 7 invalid). A float access gives exception kind 3 (alignment) and syndrome 0. A reservation access gives kind 2 (data) with 0x06000000 on a write and 0x04000000 on a read. An external access gives kind 2 with 0x06100000 or 0x04100000. A cache op completes with outAction 0, identity address and outProt 0. An invalid class gives kind 4 (program) with syndrome 0.
- R9: A direct-store integer access uses the R4 key. It is denied when it is a write with key 1 or a read with key 0; the denial is kind 2 with syndrome 0x0A000000 on a write and 0x08000000 on a read. Otherwise it completes with identity address and outProt 3'b011.
- R10: A page-table response (ptRespValid) produces walkExcValid one cycle later. A fetch gives kind 1 with 0x40000000 for no-match and 0x08000000 for protection. A data access gives kind 2 with 0x42000000 or 0x40000000 for no-match, and 0x0A000000 or 0x08000000 for protection (write or read).
- R11: Every fault carries the faulting effective address on outFaultAddr or walkExcAddr. A result that is not a fault has exception kind 0 and syndrome 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| segWrEn | input | 1 | Segment register write strobe |
| segWrIdx | input | 4 | Segment register index to write |
| segWrData | input | 32 | Segment register write value |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | 32 | Effective address |
| reqKind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| reqClass | input | 3 | Access class code |
| msrInstrReloc | input | 1 | Instruction relocation enable |
| msrDataReloc | input | 1 | Data relocation enable |
| msrUser | input | 1 | User mode |
| ptRespValid | input | 1 | Page-table fault outcome present |
| ptRespNoMatch | input | 1 | 1 no-match, 0 protection violation |
| ptRespKind | input | 2 | Access kind of the walked access |
| ptRespAddr | input | 32 | Effective address of the walked access |
| outValid | output | 1 | Result valid |
| outAction | output | 2 | 0 done, 1 walk, 2 fault |
| outRealAddr | output | 32 | Real address for a done result |
| outProt | output | 3 | Permission bits for a done result |
| outKey | output | 1 | Protection key for the walk |
| outNoExec | output | 1 | No-execute flag for the walk |
| outHash | output | 24 | Primary hash for the walk |
| outTag | output | 31 | Compare tag for the walk |
| outExcKind | output | 3 | 0 none, 1 instruction, 2 data, 3 alignment, 4 program |
| outSyndrome | output | 32 | Syndrome word |
| outFaultAddr | output | 32 | Faulting effective address |
| walkExcValid | output | 1 | Walk fault result valid |
| walkExcKind | output | 3 | Exception kind for the walk fault |
| walkExcSyndrome | output | 32 | Syndrome for the walk fault |
| walkExcAddr | output | 32 | Faulting address for the walk fault |

## Verification
The assertions check on every cycle the one-cycle result timing of both channels and the identity mapping whenever relocation is off. They also check that a fetch never leaves as a walk on a no-execute segment, that fault action and non-zero exception kind always go together with the faulting address attached, and that instruction faults only carry one of the three instruction syndromes. Only the bench's scenarios can show the exact syndrome chosen for each class and kind, the key selection and the inverted-looking direct-store key rule, the I/O bypass address splice, and that hash and tag come from the segment written before the request.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  localparam int SR_W      = 32;
  localparam int SR_T_BIT  = 31;
  localparam int SR_KS_BIT = 30;
  localparam int SR_KP_BIT = 29;
  localparam int SR_NX_BIT = 28;
  localparam int BUID_HI   = 28;
  localparam int BUID_LO   = 20;
  localparam logic [BUID_HI-BUID_LO:0] IO_BYPASS_ID = 9'h07F;
  localparam int SYN_W     = 32;

  localparam logic [1:0] KIND_READ  = 2'd0;
  localparam logic [1:0] KIND_WRITE = 2'd1;
  localparam logic [1:0] KIND_FETCH = 2'd2;

  localparam logic [2:0] CLS_INT   = 3'd0;
  localparam logic [2:0] CLS_FLOAT = 3'd1;
  localparam logic [2:0] CLS_RES   = 3'd2;
  localparam logic [2:0] CLS_CACHE = 3'd3;
  localparam logic [2:0] CLS_EXT   = 3'd4;

  localparam logic [2:0] PROT_NONE = 3'b000;
  localparam logic [2:0] PROT_RW   = 3'b011;
  localparam logic [2:0] PROT_ALL  = 3'b111;

  typedef enum logic [1:0] {
    ACT_DONE  = 2'd0,
    ACT_WALK  = 2'd1,
    ACT_FAULT = 2'd2
  } act_e;

  typedef enum logic [2:0] {
    EXC_NONE    = 3'd0,
    EXC_INSTR   = 3'd1,
    EXC_DATA    = 3'd2,
    EXC_ALIGN   = 3'd3,
    EXC_PROGRAM = 3'd4
  } exc_e;

  typedef enum logic [3:0] {
    FLT_NONE,
    FLT_NOMATCH,
    FLT_PROT,
    FLT_NOEXEC,
    FLT_DS_FETCH,
    FLT_DS_FLOAT,
    FLT_DS_RES,
    FLT_DS_EXT,
    FLT_BAD_CLASS
  } flt_e;

  // control -> datapath strobes
  typedef struct packed {
    logic       load;
    act_e       action;
    logic [2:0] prot;
    logic       addrBypass;
    flt_e       fault;
  } seg_strobe_t;

endpackage

// File: rtl/seg_fault_enc.sv
module seg_fault_enc
  import seg_xlate_pkg::*;
(
  input  flt_e             fault,
  input  logic [1:0]       kind,
  output logic [2:0]       excKind,
  output logic [SYN_W-1:0] syndrome
);

  logic isFetch;
  logic isWrite;

  assign isFetch = (kind == KIND_FETCH);
  assign isWrite = (kind == KIND_WRITE);

  always_comb begin
    excKind  = EXC_NONE;
    syndrome = '0;
    unique case (fault)
      FLT_NOMATCH: begin
        excKind  = isFetch ? EXC_INSTR : EXC_DATA;
        syndrome = (!isFetch && isWrite) ? 32'h4200_0000 : 32'h4000_0000;
      end
      FLT_PROT: begin
        excKind  = isFetch ? EXC_INSTR : EXC_DATA;
        syndrome = (!isFetch && isWrite) ? 32'h0A00_0000 : 32'h0800_0000;
      end
      FLT_NOEXEC, FLT_DS_FETCH: begin
        excKind  = EXC_INSTR;
        syndrome = 32'h1000_0000;
      end
      FLT_DS_FLOAT: begin
        excKind  = EXC_ALIGN;
        syndrome = '0;
      end
      FLT_DS_RES: begin
        excKind  = EXC_DATA;
        syndrome = isWrite ? 32'h0600_0000 : 32'h0400_0000;
      end
      FLT_DS_EXT: begin
        excKind  = EXC_DATA;
        syndrome = isWrite ? 32'h0610_0000 : 32'h0410_0000;
      end
      FLT_BAD_CLASS: begin
        excKind  = EXC_PROGRAM;
        syndrome = '0;
      end
      default: begin
        excKind  = EXC_NONE;
        syndrome = '0;
      end
    endcase
  end

endmodule

// File: rtl/seg_ctrl.sv
module seg_ctrl
  import seg_xlate_pkg::*;
(
  input  logic        reqValid,
  input  logic [1:0]  reqKind,
  input  logic [2:0]  reqClass,
  input  logic        msrInstrReloc,
  input  logic        msrDataReloc,
  input  logic        segT,
  input  logic        segBypass,
  input  logic        segNx,
  input  logic        segKey,
  output seg_strobe_t strobe
);

  logic isFetch;
  logic isWrite;
  logic relocOn;

  assign isFetch = (reqKind == KIND_FETCH);
  assign isWrite = (reqKind == KIND_WRITE);
  assign relocOn = isFetch ? msrInstrReloc : msrDataReloc;

  always_comb begin
    strobe            = '0;
    strobe.load       = reqValid;
    strobe.action     = ACT_DONE;
    strobe.prot       = PROT_NONE;
    strobe.addrBypass = 1'b0;
    strobe.fault      = FLT_NONE;

    if (!relocOn) begin
      strobe.prot = PROT_ALL;
    end else if (segT) begin
      if (segBypass) begin
        strobe.prot       = PROT_ALL;
        strobe.addrBypass = 1'b1;
      end else if (isFetch) begin
        strobe.fault = FLT_DS_FETCH;
      end else begin
        case (reqClass)
          CLS_INT: begin
            if ((isWrite && segKey) || (!isWrite && !segKey)) begin
              strobe.fault = FLT_PROT;
            end else begin
              strobe.prot = PROT_RW;
            end
          end
          CLS_FLOAT: strobe.fault = FLT_DS_FLOAT;
          CLS_RES:   strobe.fault = FLT_DS_RES;
          CLS_CACHE: strobe.prot  = PROT_NONE;
          CLS_EXT:   strobe.fault = FLT_DS_EXT;
          default:   strobe.fault = FLT_BAD_CLASS;
        endcase
      end
    end else if (isFetch && segNx) begin
      strobe.fault = FLT_NOEXEC;
    end else begin
      strobe.action = ACT_WALK;
    end

    if (strobe.fault != FLT_NONE) begin
      strobe.action = ACT_FAULT;
    end
  end

endmodule

// File: rtl/seg_datapath.sv
module seg_datapath
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SEG_SEL_W  = 4,
  parameter int PAGE_SHIFT = 12,
  parameter int VSID_W     = 24,
  parameter int API_W      = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      segWrEn,
  input  logic [SEG_SEL_W-1:0]      segWrIdx,
  input  logic [SR_W-1:0]           segWrData,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [1:0]                reqKind,
  input  logic                      msrUser,
  input  seg_strobe_t               strobe,
  input  logic                      ptRespValid,
  input  logic                      ptRespNoMatch,
  input  logic [1:0]                ptRespKind,
  input  logic [ADDR_W-1:0]         ptRespAddr,
  output logic                      segT,
  output logic                      segBypass,
  output logic                      segNx,
  output logic                      segKey,
  output logic                      outValid,
  output logic [1:0]                outAction,
  output logic [ADDR_W-1:0]         outRealAddr,
  output logic [2:0]                outProt,
  output logic                      outKey,
  output logic                      outNoExec,
  output logic [VSID_W-1:0]         outHash,
  output logic [VSID_W+API_W:0]     outTag,
  output logic [2:0]                outExcKind,
  output logic [SYN_W-1:0]          outSyndrome,
  output logic [ADDR_W-1:0]         outFaultAddr,
  output logic                      walkExcValid,
  output logic [2:0]                walkExcKind,
  output logic [SYN_W-1:0]          walkExcSyndrome,
  output logic [ADDR_W-1:0]         walkExcAddr
);

  localparam int NUM_SEGS = 1 << SEG_SEL_W;
  localparam int OFFS_W   = ADDR_W - SEG_SEL_W;
  localparam int PIDX_W   = OFFS_W - PAGE_SHIFT;
  localparam int TAG_W    = VSID_W + 1 + API_W;

  logic [SR_W-1:0]      segRegs [NUM_SEGS];
  logic [SR_W-1:0]      selSeg;
  logic [VSID_W-1:0]    vsid;
  logic [PIDX_W-1:0]    pageIdx;
  logic [VSID_W-1:0]    hashNext;
  logic [TAG_W-1:0]     tagNext;
  logic [ADDR_W-1:0]    bypassAddr;
  logic [2:0]           reqExcKind;
  logic [SYN_W-1:0]     reqSyndrome;
  flt_e                 walkFault;
  logic [2:0]           walkKindNext;
  logic [SYN_W-1:0]     walkSynNext;

  // segment register file, one register per index
  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        segRegs[g] <= '0;
      end else if (segWrEn && (segWrIdx == SEG_SEL_W'(g))) begin
        segRegs[g] <= segWrData;
      end
    end
  end

  assign selSeg    = segRegs[reqAddr[ADDR_W-1 -: SEG_SEL_W]];
  assign segT      = selSeg[SR_T_BIT];
  assign segNx     = selSeg[SR_NX_BIT];
  assign segKey    = msrUser ? selSeg[SR_KP_BIT] : selSeg[SR_KS_BIT];
  assign segBypass = (selSeg[BUID_HI:BUID_LO] == IO_BYPASS_ID);

  assign vsid       = selSeg[VSID_W-1:0];
  assign pageIdx    = reqAddr[OFFS_W-1:PAGE_SHIFT];
  assign hashNext   = vsid ^ VSID_W'(pageIdx);
  assign tagNext    = {vsid, 1'b0, pageIdx[PIDX_W-1 -: API_W]};
  assign bypassAddr = {selSeg[SEG_SEL_W-1:0], reqAddr[OFFS_W-1:0]};

  seg_fault_enc reqEnc_i (
    .fault    (strobe.fault),
    .kind     (reqKind),
    .excKind  (reqExcKind),
    .syndrome (reqSyndrome)
  );

  assign walkFault = ptRespNoMatch ? FLT_NOMATCH : FLT_PROT;

  seg_fault_enc walkEnc_i (
    .fault    (walkFault),
    .kind     (ptRespKind),
    .excKind  (walkKindNext),
    .syndrome (walkSynNext)
  );

  // request result register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid     <= 1'b0;
      outAction    <= '0;
      outRealAddr  <= '0;
      outProt      <= '0;
      outKey       <= 1'b0;
      outNoExec    <= 1'b0;
      outHash      <= '0;
      outTag       <= '0;
      outExcKind   <= '0;
      outSyndrome  <= '0;
      outFaultAddr <= '0;
    end else begin
      outValid <= strobe.load;
      if (strobe.load) begin
        outAction    <= strobe.action;
        outRealAddr  <= strobe.addrBypass ? bypassAddr : reqAddr;
        outProt      <= strobe.prot;
        outKey       <= segKey;
        outNoExec    <= segNx;
        outHash      <= hashNext;
        outTag       <= tagNext;
        outExcKind   <= reqExcKind;
        outSyndrome  <= reqSyndrome;
        outFaultAddr <= (strobe.fault != FLT_NONE) ? reqAddr : '0;
      end
    end
  end

  // walk outcome register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      walkExcValid    <= 1'b0;
      walkExcKind     <= '0;
      walkExcSyndrome <= '0;
      walkExcAddr     <= '0;
    end else begin
      walkExcValid <= ptRespValid;
      if (ptRespValid) begin
        walkExcKind     <= walkKindNext;
        walkExcSyndrome <= walkSynNext;
        walkExcAddr     <= ptRespAddr;
      end
    end
  end

endmodule

// File: rtl/seg_xlate_front.sv
module seg_xlate_front
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SEG_SEL_W  = 4,
  parameter int PAGE_SHIFT = 12,
  parameter int VSID_W     = 24,
  parameter int API_W      = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  segWrEn,
  input  logic [SEG_SEL_W-1:0]  segWrIdx,
  input  logic [31:0]           segWrData,
  input  logic                  reqValid,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [1:0]            reqKind,
  input  logic [2:0]            reqClass,
  input  logic                  msrInstrReloc,
  input  logic                  msrDataReloc,
  input  logic                  msrUser,
  input  logic                  ptRespValid,
  input  logic                  ptRespNoMatch,
  input  logic [1:0]            ptRespKind,
  input  logic [ADDR_W-1:0]     ptRespAddr,
  output logic                  outValid,
  output logic [1:0]            outAction,
  output logic [ADDR_W-1:0]     outRealAddr,
  output logic [2:0]            outProt,
  output logic                  outKey,
  output logic                  outNoExec,
  output logic [VSID_W-1:0]     outHash,
  output logic [VSID_W+API_W:0] outTag,
  output logic [2:0]            outExcKind,
  output logic [31:0]           outSyndrome,
  output logic [ADDR_W-1:0]     outFaultAddr,
  output logic                  walkExcValid,
  output logic [2:0]            walkExcKind,
  output logic [31:0]           walkExcSyndrome,
  output logic [ADDR_W-1:0]     walkExcAddr
);

  seg_strobe_t strobe;
  logic        segT;
  logic        segBypass;
  logic        segNx;
  logic        segKey;

  seg_ctrl ctrl_i (
    .reqValid      (reqValid),
    .reqKind       (reqKind),
    .reqClass      (reqClass),
    .msrInstrReloc (msrInstrReloc),
    .msrDataReloc  (msrDataReloc),
    .segT          (segT),
    .segBypass     (segBypass),
    .segNx         (segNx),
    .segKey        (segKey),
    .strobe        (strobe)
  );

  seg_datapath #(
    .ADDR_W     (ADDR_W),
    .SEG_SEL_W  (SEG_SEL_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .VSID_W     (VSID_W),
    .API_W      (API_W)
  ) dp_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .segWrEn         (segWrEn),
    .segWrIdx        (segWrIdx),
    .segWrData       (segWrData),
    .reqAddr         (reqAddr),
    .reqKind         (reqKind),
    .msrUser         (msrUser),
    .strobe          (strobe),
    .ptRespValid     (ptRespValid),
    .ptRespNoMatch   (ptRespNoMatch),
    .ptRespKind      (ptRespKind),
    .ptRespAddr      (ptRespAddr),
    .segT            (segT),
    .segBypass       (segBypass),
    .segNx           (segNx),
    .segKey          (segKey),
    .outValid        (outValid),
    .outAction       (outAction),
    .outRealAddr     (outRealAddr),
    .outProt         (outProt),
    .outKey          (outKey),
    .outNoExec       (outNoExec),
    .outHash         (outHash),
    .outTag          (outTag),
    .outExcKind      (outExcKind),
    .outSyndrome     (outSyndrome),
    .outFaultAddr    (outFaultAddr),
    .walkExcValid    (walkExcValid),
    .walkExcKind     (walkExcKind),
    .walkExcSyndrome (walkExcSyndrome),
    .walkExcAddr     (walkExcAddr)
  );

endmodule

// File: rtl/seg_xlate_front_chk.sv
module seg_xlate_front_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [1:0]        reqKind,
  input logic              msrInstrReloc,
  input logic              msrDataReloc,
  input logic              ptRespValid,
  input logic [ADDR_W-1:0] ptRespAddr,
  input logic              outValid,
  input logic [1:0]        outAction,
  input logic [ADDR_W-1:0] outRealAddr,
  input logic [2:0]        outProt,
  input logic              outNoExec,
  input logic [2:0]        outExcKind,
  input logic [31:0]       outSyndrome,
  input logic [ADDR_W-1:0] outFaultAddr,
  input logic              walkExcValid,
  input logic [2:0]        walkExcKind,
  input logic [ADDR_W-1:0] walkExcAddr
);

  p_out_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> outValid);

  p_out_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !outValid);

  p_fetch_reloc_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqKind == 2'd2 && !msrInstrReloc) |=>
      (outAction == 2'd0 && outRealAddr == $past(reqAddr) && outProt == 3'b111));

  p_data_reloc_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqKind != 2'd2 && !msrDataReloc) |=>
      (outAction == 2'd0 && outRealAddr == $past(reqAddr) && outProt == 3'b111));

  p_fetch_never_walks_noexec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqKind == 2'd2) |=> !(outAction == 2'd1 && outNoExec));

  p_instr_syndrome_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outExcKind == 3'd1) |->
      (outSyndrome == 32'h1000_0000 || outSyndrome == 32'h4000_0000 ||
       outSyndrome == 32'h0800_0000));

  p_fault_has_kind_r11: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> ((outAction == 2'd2) == (outExcKind != 3'd0)));

  p_fault_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> (outAction != 2'd2 || outFaultAddr == $past(reqAddr)));

  p_walk_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ptRespValid |=> walkExcValid);

  p_walk_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ptRespValid |=> !walkExcValid);

  p_walk_kind_r10: assert property (@(posedge clk) disable iff (!rst_n)
    walkExcValid |-> (walkExcKind == 3'd1 || walkExcKind == 3'd2));

  p_walk_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ptRespValid |=> (walkExcAddr == $past(ptRespAddr)));

endmodule

bind seg_xlate_front seg_xlate_front_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .reqValid      (reqValid),
  .reqAddr       (reqAddr),
  .reqKind       (reqKind),
  .msrInstrReloc (msrInstrReloc),
  .msrDataReloc  (msrDataReloc),
  .ptRespValid   (ptRespValid),
  .ptRespAddr    (ptRespAddr),
  .outValid      (outValid),
  .outAction     (outAction),
  .outRealAddr   (outRealAddr),
  .outProt       (outProt),
  .outNoExec     (outNoExec),
  .outExcKind    (outExcKind),
  .outSyndrome   (outSyndrome),
  .outFaultAddr  (outFaultAddr),
  .walkExcValid  (walkExcValid),
  .walkExcKind   (walkExcKind),
  .walkExcAddr   (walkExcAddr)
);

// File: tb/seg_xlate_front_tb_top.sv
module seg_xlate_front_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        segWrEn = 1'b0;
  logic [3:0]  segWrIdx = '0;
  logic [31:0] segWrData = '0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqKind = '0;
  logic [2:0]  reqClass = '0;
  logic        msrInstrReloc = 1'b1;
  logic        msrDataReloc = 1'b1;
  logic        msrUser = 1'b0;
  logic        ptRespValid = 1'b0;
  logic        ptRespNoMatch = 1'b0;
  logic [1:0]  ptRespKind = '0;
  logic [31:0] ptRespAddr = '0;
  logic        outValid;
  logic [1:0]  outAction;
  logic [31:0] outRealAddr;
  logic [2:0]  outProt;
  logic        outKey;
  logic        outNoExec;
  logic [23:0] outHash;
  logic [30:0] outTag;
  logic [2:0]  outExcKind;
  logic [31:0] outSyndrome;
  logic [31:0] outFaultAddr;
  logic        walkExcValid;
  logic [2:0]  walkExcKind;
  logic [31:0] walkExcSyndrome;
  logic [31:0] walkExcAddr;

  always #4 clk = ~clk;  // 125 MHz

  seg_xlate_front dut_i (.*);

  typedef struct {
    string       req;
    logic [1:0]  act;
    logic [31:0] addr;
    logic [2:0]  prot;
    logic        key;
    logic        nx;
    logic [23:0] hash;
    logic [30:0] tag;
    logic [2:0]  exc;
    logic [31:0] syn;
    logic [31:0] faddr;
  } exp_t;

  typedef struct {
    string       req;
    logic [2:0]  exc;
    logic [31:0] syn;
    logic [31:0] faddr;
  } wexp_t;

  exp_t  reqQ[$];
  wexp_t walkQ[$];
  int    nChecks = 0;
  int    nFails = 0;
  bit    finished = 0;

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] want);
    nChecks++;
    if (got !== want) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, want);
    end
  endtask

  function automatic exp_t mkDone(string req, logic [31:0] a, logic [2:0] p);
    exp_t e;
    e = '{req: req, act: 2'd0, addr: a, prot: p, key: 0, nx: 0, hash: 0, tag: 0,
          exc: 0, syn: 0, faddr: 0};
    return e;
  endfunction

  function automatic exp_t mkWalk(string req, logic [23:0] vsid, logic [31:0] ea,
                                  logic k, logic n);
    exp_t e;
    e = '{req: req, act: 2'd1, addr: 0, prot: 0, key: k, nx: n,
          hash: vsid ^ {8'h00, ea[27:12]}, tag: {vsid, 1'b0, ea[27:22]},
          exc: 0, syn: 0, faddr: 0};
    return e;
  endfunction

  function automatic exp_t mkFault(string req, logic [2:0] x, logic [31:0] s, logic [31:0] ea);
    exp_t e;
    e = '{req: req, act: 2'd2, addr: 0, prot: 0, key: 0, nx: 0, hash: 0, tag: 0,
          exc: x, syn: s, faddr: ea};
    return e;
  endfunction

  task automatic writeSeg(logic [3:0] idx, logic [31:0] val);
    @(negedge clk);
    reqValid  = 1'b0;
    segWrEn   = 1'b1;
    segWrIdx  = idx;
    segWrData = val;
    @(negedge clk);
    segWrEn = 1'b0;
  endtask

  task automatic sendReq(logic [31:0] a, logic [1:0] k, logic [2:0] c,
                         logic ir, logic dr, logic u, exp_t e);
    @(negedge clk);
    reqValid      = 1'b1;
    reqAddr       = a;
    reqKind       = k;
    reqClass      = c;
    msrInstrReloc = ir;
    msrDataReloc  = dr;
    msrUser       = u;
    reqQ.push_back(e);
  endtask

  task automatic sendWalk(logic nm, logic [1:0] k, logic [31:0] a, wexp_t e);
    @(negedge clk);
    ptRespValid   = 1'b1;
    ptRespNoMatch = nm;
    ptRespKind    = k;
    ptRespAddr    = a;
    walkQ.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid    = 1'b0;
    ptRespValid = 1'b0;
  endtask

  // monitor: request results
  always @(negedge clk) begin
    if (rst_n && outValid) begin
      if (reqQ.size() == 0) begin
        check("R2", "unexpected outValid", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = reqQ.pop_front();
        check(e.req, "action", 32'(outAction), 32'(e.act));
        check(e.req, "excKind", 32'(outExcKind), 32'(e.exc));
        check(e.req, "syndrome", outSyndrome, e.syn);
        if (e.act == 2'd0) begin
          check(e.req, "realAddr", outRealAddr, e.addr);
          check(e.req, "prot", 32'(outProt), 32'(e.prot));
        end else if (e.act == 2'd1) begin
          check(e.req, "key", 32'(outKey), 32'(e.key));
          check(e.req, "noExec", 32'(outNoExec), 32'(e.nx));
          check(e.req, "hash", 32'(outHash), 32'(e.hash));
          check(e.req, "tag", 32'(outTag), 32'(e.tag));
        end else begin
          check(e.req, "faultAddr R11", outFaultAddr, e.faddr);
        end
      end
    end
  end

  // monitor: walk outcomes
  always @(negedge clk) begin
    if (rst_n && walkExcValid) begin
      if (walkQ.size() == 0) begin
        check("R10", "unexpected walkExcValid", 32'd1, 32'd0);
      end else begin
        wexp_t w;
        w = walkQ.pop_front();
        check(w.req, "walkExcKind", 32'(walkExcKind), 32'(w.exc));
        check(w.req, "walkSyndrome", walkExcSyndrome, w.syn);
        check(w.req, "walkAddr R11", walkExcAddr, w.faddr);
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    localparam logic [31:0] SEG1 = 32'h4012_3456;  // ks=1 kp=0 nx=0 vsid 123456
    localparam logic [31:0] SEG2 = 32'h3000_ABCD;  // kp=1 nx=1 vsid 00ABCD
    localparam logic [31:0] SEG3 = 32'h87F0_000A;  // direct store, io bypass, low nibble A
    localparam logic [31:0] SEG4 = 32'hA120_0000;  // direct store ks=0 kp=1
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "outValid in reset", 32'(outValid), 32'd0);
    check("R1", "walkExcValid in reset", 32'(walkExcValid), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "outValid after reset", 32'(outValid), 32'd0);
    check("R1", "walkExcValid after reset", 32'(walkExcValid), 32'd0);

    writeSeg(4'd1, SEG1);
    writeSeg(4'd2, SEG2);
    writeSeg(4'd3, SEG3);
    writeSeg(4'd4, SEG4);

    // R4 ordinary segment walks, key by mode
    sendReq(32'h1ABC_D123, 2'd0, 3'd0, 1, 1, 0, mkWalk("R4", 24'h123456, 32'h1ABC_D123, 1, 0));
    sendReq(32'h1ABC_D123, 2'd1, 3'd1, 1, 1, 1, mkWalk("R4", 24'h123456, 32'h1ABC_D123, 0, 0));
    sendReq(32'h1FFF_F000, 2'd2, 3'd0, 1, 1, 0, mkWalk("R4", 24'h123456, 32'h1FFF_F000, 1, 0));
    // R5 no-execute segment
    sendReq(32'h2000_1040, 2'd2, 3'd0, 1, 1, 1,
            mkFault("R5", 3'd1, 32'h1000_0000, 32'h2000_1040));
    sendReq(32'h2345_6000, 2'd0, 3'd0, 1, 1, 1, mkWalk("R5", 24'h00ABCD, 32'h2345_6000, 1, 1));
    // R3 relocation off
    sendReq(32'h2000_0040, 2'd2, 3'd0, 0, 1, 1, mkDone("R3", 32'h2000_0040, 3'b111));
    sendReq(32'h4000_0100, 2'd1, 3'd2, 1, 0, 0, mkDone("R3", 32'h4000_0100, 3'b111));
    sendReq(32'h1234_5678, 2'd3, 3'd0, 1, 0, 0, mkDone("R3", 32'h1234_5678, 3'b111));
    // R6 io bypass segment
    sendReq(32'h3123_4567, 2'd1, 3'd1, 1, 1, 0, mkDone("R6", 32'hA123_4567, 3'b111));
    sendReq(32'h3FED_CBA8, 2'd2, 3'd0, 1, 1, 1, mkDone("R6", 32'hAFED_CBA8, 3'b111));
    // R7 direct store fetch
    sendReq(32'h4000_0200, 2'd2, 3'd0, 1, 1, 0,
            mkFault("R7", 3'd1, 32'h1000_0000, 32'h4000_0200));
    // R8 class filtering
    sendReq(32'h4000_0300, 2'd0, 3'd1, 1, 1, 0, mkFault("R8", 3'd3, 32'h0, 32'h4000_0300));
    sendReq(32'h4000_0304, 2'd1, 3'd2, 1, 1, 0,
            mkFault("R8", 3'd2, 32'h0600_0000, 32'h4000_0304));
    sendReq(32'h4000_0308, 2'd0, 3'd2, 1, 1, 0,
            mkFault("R8", 3'd2, 32'h0400_0000, 32'h4000_0308));
    sendReq(32'h4000_030C, 2'd1, 3'd4, 1, 1, 0,
            mkFault("R8", 3'd2, 32'h0610_0000, 32'h4000_030C));
    sendReq(32'h4000_0310, 2'd0, 3'd4, 1, 1, 0,
            mkFault("R8", 3'd2, 32'h0410_0000, 32'h4000_0310));
    sendReq(32'h4000_0314, 2'd1, 3'd3, 1, 1, 0, mkDone("R8", 32'h4000_0314, 3'b000));
    sendReq(32'h4000_0318, 2'd0, 3'd6, 1, 1, 0, mkFault("R8", 3'd4, 32'h0, 32'h4000_0318));
    // R9 direct store integer key rule (user -> key 1, supervisor -> key 0)
    sendReq(32'h4000_0400, 2'd1, 3'd0, 1, 1, 1,
            mkFault("R9", 3'd2, 32'h0A00_0000, 32'h4000_0400));
    sendReq(32'h4000_0404, 2'd0, 3'd0, 1, 1, 1, mkDone("R9", 32'h4000_0404, 3'b011));
    sendReq(32'h4000_0408, 2'd0, 3'd0, 1, 1, 0,
            mkFault("R9", 3'd2, 32'h0800_0000, 32'h4000_0408));
    sendReq(32'h4000_040C, 2'd1, 3'd0, 1, 1, 0, mkDone("R9", 32'h4000_040C, 3'b011));
    idle();

    // R2: rewritten segment is used by the next request
    writeSeg(4'd1, 32'h4000_0F0F);
    sendReq(32'h1ABC_D123, 2'd0, 3'd0, 1, 1, 0, mkWalk("R2", 24'h000F0F, 32'h1ABC_D123, 1, 0));
    idle();

    // R10 walk outcome mapping
    sendWalk(1, 2'd2, 32'h5000_0000, '{req: "R10", exc: 3'd1, syn: 32'h4000_0000, faddr: 32'h5000_0000});
    sendWalk(0, 2'd2, 32'h5000_0004, '{req: "R10", exc: 3'd1, syn: 32'h0800_0000, faddr: 32'h5000_0004});
    sendWalk(1, 2'd1, 32'h5000_0008, '{req: "R10", exc: 3'd2, syn: 32'h4200_0000, faddr: 32'h5000_0008});
    sendWalk(1, 2'd0, 32'h5000_000C, '{req: "R10", exc: 3'd2, syn: 32'h4000_0000, faddr: 32'h5000_000C});
    sendWalk(0, 2'd1, 32'h5000_0010, '{req: "R10", exc: 3'd2, syn: 32'h0A00_0000, faddr: 32'h5000_0010});
    sendWalk(0, 2'd0, 32'h5000_0014, '{req: "R10", exc: 3'd2, syn: 32'h0800_0000, faddr: 32'h5000_0014});
    sendWalk(1, 2'd3, 32'h5000_0018, '{req: "R10", exc: 3'd2, syn: 32'h4000_0000, faddr: 32'h5000_0018});
    idle();

    repeat (4) @(negedge clk);
    check("R2", "pending request results", 32'(reqQ.size()), 32'd0);
    check("R10", "pending walk results", 32'(walkQ.size()), 32'd0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule